// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Literal Operand and Sign Flags

This block is the arithmetic stage of a small 16-bit accumulator-style datapath. A combinational unit computes an addition, a bitwise AND, a bitwise complement or a plain copy of its first operand. For the addition and the AND, the second operand comes from one of two places. In register mode it is the second register-file read port. In literal mode it is a 5-bit two's-complement constant held in the low bits of the current instruction word, widened to the data width by copying its sign bit. One bit of the instruction chooses between the two modes.

Beside the ALU sits a three-bit sign register that classifies a data word as negative, zero or positive. It does not look at the ALU result. It samples whatever value the surrounding datapath is driving onto its shared bus, on each clock edge where its load strobe is high. Read-port decoding and bus arbitration are handled elsewhere. The sign register is cleared to the zero state by a synchronous reset.

Top module: `alu_imm_cc`

## Requirements
- R1: With op_sel = 2'b00 (add) and instr[5] = 0, result equals (src_a + src_b) modulo 2^16, with no cycle of delay.
- R2: With op_sel = 2'b00 and instr[5] = 1, result equals (src_a + sext(instr[4:0])) modulo 2^16, and src_b has no effect.
- R3: With op_sel = 2'b01 (and), result equals src_a & src_b when instr[5] = 0, and src_a & sext(instr[4:0]) when instr[5] = 1.
- R4: With op_sel = 2'b10, result equals ~src_a. Neither src_b nor instr affects the result.
- R5: With op_sel = 2'b11, result equals src_a. Neither src_b nor instr affects the result.
- R6: The literal is sign-extended. instr[4] is copied into bits 15..5, so 5'b10000 is worth -16 (0xFFF0) and 5'b01111 is worth +15.
- R7: A clock edge with rst high sets flag_z = 1, flag_n = 0 and flag_p = 0.
- R8: A clock edge with flag_ld high and rst low captures bus_val. After that edge, flag_n = bus_val[15], flag_z = 1 only if all 16 bits were 0, and flag_p = 1 only if the value was neither negative nor zero.
- R9: A clock edge with flag_ld low and rst low leaves all three flags unchanged, whatever the value of bus_val.
- R10: After reset, exactly one of flag_n, flag_z and flag_p is 1 at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | 16 | First operand, from register read port 1 |
| src_b | input | 16 | Second operand, from register read port 2 |
| instr | input | 16 | Current instruction word; bit 5 selects the mode, bits 4..0 hold the literal |
| op_sel | input | 2 | 00 add, 01 and, 10 complement A, 11 copy A |
| bus_val | input | 16 | Value currently on the shared datapath bus |
| flag_ld | input | 1 | Sign register load strobe |
| result | output | 16 | Combinational ALU result |
| flag_n | output | 1 | Last sampled value was negative |
| flag_z | output | 1 | Last sampled value was zero |
| flag_p | output | 1 | Last sampled value was positive |

## Verification
The assertions check the sign register on every cycle: the one-hot invariant, that the flags hold while the strobe is low, the exact classification of the sampled bus word, and the state after reset. They also check that the complement and copy operations follow operand A in every cycle. The bench scenarios cover everything else. They show that the sign extension and the mode bit give the right sums and masks at the edges of the literal range (-16, -1, +15), that carries wrap at 16 bits, and that src_b and the instruction word have no effect in the modes that ignore them. Seeded random operands exercise each operation in both modes.

// File: rtl/alu_imm_pkg.sv
package alu_imm_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_AND  = 2'b01,
    OP_NOTA = 2'b10,
    OP_PASA = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } sign_flags_t;

  localparam sign_flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int W     = 16,
  parameter int IMM_W = 5
) (
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] lit,
  input  logic             lit_mode,
  input  logic [1:0]       op,
  output logic [W-1:0]     opnd_b
);
  import alu_imm_pkg::*;
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] lit_wide;
  logic         arith_op;

  assign lit_wide = {{EXT_W{lit[IMM_W-1]}}, lit};
  assign arith_op = (op == OP_ADD) || (op == OP_AND);

  always_comb begin
    if (arith_op && lit_mode) opnd_b = lit_wide;
    else                      opnd_b = reg_b;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] y
);
  import alu_imm_pkg::*;

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_AND:  y = a & b;
      OP_NOTA: y = ~a;
      OP_PASA: y = a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/alu_sign_reg.sv
module alu_sign_reg #(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld,
  input  logic [W-1:0]              val,
  output alu_imm_pkg::sign_flags_t  flags
);
  import alu_imm_pkg::*;

  sign_flags_t next_flags;

  always_comb begin
    next_flags.n = val[W-1];
    next_flags.z = ~|val;
    next_flags.p = ~next_flags.n & ~next_flags.z;
  end

  always_ff @(posedge clk) begin
    if (rst)     flags <= FLAGS_RESET;
    else if (ld) flags <= next_flags;
  end
endmodule

// File: rtl/alu_imm_cc.sv
module alu_imm_cc #(
  parameter int DATA_W   = 16,
  parameter int INSTR_W  = 16,
  parameter int IMM_W    = 5,
  parameter int MODE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [INSTR_W-1:0] instr,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              flag_ld,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);
  import alu_imm_pkg::*;

  logic [DATA_W-1:0] opnd_b;
  sign_flags_t       flags_q;
  logic              unused_instr_hi;

  assign unused_instr_hi = ^instr[INSTR_W-1:MODE_BIT+1];

  alu_opnd_sel #(.W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .reg_b    (src_b),
    .lit      (instr[IMM_W-1:0]),
    .lit_mode (instr[MODE_BIT]),
    .op       (op_sel),
    .opnd_b   (opnd_b)
  );

  alu_core #(.W(DATA_W)) u_core (
    .a  (src_a),
    .b  (opnd_b),
    .op (op_sel),
    .y  (result)
  );

  alu_sign_reg #(.W(DATA_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .ld    (flag_ld),
    .val   (bus_val),
    .flags (flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_p = flags_q.p;
endmodule

// File: rtl/alu_imm_cc_chk.sv
module alu_imm_cc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] src_a,
  input logic [1:0]   op_sel,
  input logic [W-1:0] bus_val,
  input logic         flag_ld,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_p
);
  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || $past(flag_ld) || $past(flag_n || flag_z || flag_p)
      |-> $countones({flag_n, flag_z, flag_p}) == 1);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_ld |=> $stable({flag_n, flag_z, flag_p}));

  a_r8_neg: assert property (@(posedge clk) disable iff (rst)
    flag_ld |=> flag_n == $past(bus_val[W-1]));

  a_r8_zero: assert property (@(posedge clk) disable iff (rst)
    flag_ld |=> flag_z == ($past(bus_val) == '0));

  a_r8_pos: assert property (@(posedge clk) disable iff (rst)
    flag_ld |=> flag_p == (!$past(bus_val[W-1]) && $past(bus_val) != '0));

  a_r7_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (flag_z && !flag_n && !flag_p));

  a_r4_not_a: assert property (@(posedge clk) disable iff (rst)
    op_sel == 2'b10 |-> result == ~src_a);

  a_r5_copy_a: assert property (@(posedge clk) disable iff (rst)
    op_sel == 2'b11 |-> result == src_a);
endmodule

bind alu_imm_cc alu_imm_cc_chk #(.W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_a   (src_a),
  .op_sel  (op_sel),
  .bus_val (bus_val),
  .flag_ld (flag_ld),
  .result  (result),
  .flag_n  (flag_n),
  .flag_z  (flag_z),
  .flag_p  (flag_p)
);

// File: tb/tb_alu_imm_cc.sv
module tb_alu_imm_cc;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] src_a, src_b, instr, bus_val, result;
  logic [1:0]  op_sel;
  logic        flag_ld, flag_n, flag_z, flag_p;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_nzp = 3'b010;

  always #5 clk = ~clk;

  alu_imm_cc dut (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .instr(instr),
    .op_sel(op_sel), .bus_val(bus_val), .flag_ld(flag_ld),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  function automatic logic [15:0] sext5(input logic [4:0] v);
    return {{11{v[4]}}, v};
  endfunction

  function automatic logic [15:0] model_alu(input logic [15:0] a, input logic [15:0] b,
                                            input logic [15:0] ins, input logic [1:0] op);
    logic [15:0] bb;
    bb = ins[5] ? sext5(ins[4:0]) : b;
    case (op)
      2'b00:   return a + bb;
      2'b01:   return a & bb;
      2'b10:   return ~a;
      default: return a;
    endcase
  endfunction

  function automatic logic [2:0] model_nzp(input logic [15:0] v);
    if (v[15])      return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  function automatic string req_of(input logic [1:0] op, input logic mode);
    case (op)
      2'b00:   return mode ? "R2" : "R1";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] ins, input logic [1:0] op,
                      input logic [15:0] bv, input logic ld);
    @(negedge clk);
    src_a = a; src_b = b; instr = ins; op_sel = op; bus_val = bv; flag_ld = ld;
    #1;
    chk(req, result, model_alu(a, b, ins, op));
    @(posedge clk);
    if (ld) exp_nzp = model_nzp(bv);
    @(negedge clk);
    chk(ld ? "R8" : "R9", {13'b0, flag_n, flag_z, flag_p}, {13'b0, exp_nzp});
    flag_ld = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; src_a = '0; src_b = '0; instr = '0; op_sel = '0;
    bus_val = 16'h8000; flag_ld = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", {13'b0, flag_n, flag_z, flag_p}, 16'h0002);
    rst = 1'b0; flag_ld = 1'b0;
    exp_nzp = 3'b010;

    // R6 literal edges: -16, +15, -1
    step("R6", 16'h0010, 16'h1234, 16'h0030, 2'b00, 16'h0000, 1'b0);
    step("R6", 16'hFFFF, 16'h0000, 16'h002F, 2'b00, 16'h8000, 1'b1);
    step("R6", 16'hA5C3, 16'h0000, 16'h003F, 2'b01, 16'h0000, 1'b1);
    step("R2", 16'h7FFF, 16'hFFFF, 16'h0021, 2'b00, 16'h7FFF, 1'b1);
    // R1 wrap at 16 bits
    step("R1", 16'hFFFF, 16'h0001, 16'hFFDF, 2'b00, 16'h0001, 1'b0);
    step("R3", 16'hF0F0, 16'h3C3C, 16'h0000, 2'b01, 16'hFFFF, 1'b1);
    // R4/R5: src_b and instr ignored
    step("R4", 16'h1357, 16'hFFFF, 16'hFFFF, 2'b10, 16'h0000, 1'b0);
    step("R5", 16'h1357, 16'h0000, 16'h003F, 2'b11, 16'h0000, 1'b1);
    step("R9", 16'h0000, 16'h0000, 16'h0000, 2'b11, 16'h8000, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b, ins, bv;
      logic [1:0]  op;
      a = 16'($urandom); b = 16'($urandom); ins = 16'($urandom);
      op = 2'($urandom); bv = 16'($urandom);
      if (($urandom % 8) == 0) bv = 16'h0000;
      step(req_of(op, ins[5]), a, b, ins, op, bv, 1'($urandom));
      // R10 one-hot at ports
      chk("R10", 16'($countones({flag_n, flag_z, flag_p})), 16'd1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule